// File: doc/BRIEF.md
# Interrupt Signaling Mode Selector

This block sits between device logic that raises interrupt requests on a set of vectors and the transmit side that turns message requests into packets. It watches the request inputs and, depending on which signaling mode is enabled, produces one of three kinds of message request. In legacy mode the OR of all request lines is treated as a single level-sensitive wire, and every change of that level becomes a wire-assert or wire-deassert message that carries the configured pin code. In single-address message mode each new request becomes a memory write to one programmed address, and the vector number is merged into the data. In table mode each vector's write uses its own address and data, which are held in a small internal table loaded through a write port.

Every message request leaves on a valid/ready stream. When `out_valid` is high, `out_kind`, `out_addr` and `out_data` hold still until `out_ready` is seen high on a clock edge. Only one request is offered at a time. Back-pressure is therefore unlimited: new vector edges collect in per-vector pending bits and the wire state does not change until the consumer accepts. When a message mode is switched on while the legacy wire is still asserted, the block first sends one wire-deassert so that the wire is not left stuck.

Top module: `irq_signal_sel`

## Requirements
- R1: After reset `out_valid` is 0, no vector is pending and the legacy wire is taken as deasserted.
- R2: With `msi_en` and `msix_en` both 0, a change of the OR of `irq_req` from 0 to 1 offers one message with `out_kind` = 0 (wire assert), `out_addr` = 0 and `out_data` = `intx_pin` zero-extended (0=A, 1=B, 2=C, 3=D). Further lines rising while the wire is asserted offer nothing.
- R3: In legacy mode, after an accepted assert, the OR of `irq_req` falling to 0 offers one message with `out_kind` = 1 (wire deassert), `out_addr` = 0 and `out_data` = pin code.
- R4: While `msi_en` or `msix_en` is 1, no wire-assert message is offered. If the wire is asserted when a message mode becomes enabled, one wire-deassert is offered before any memory write.
- R5: With `msi_en` = 1 and `msix_en` = 0, a vector write has `out_kind` = 2, `out_addr` = `msi_addr` and `out_data` = `msi_data` OR the vector number.
- R6: With `msix_en` = 1, whatever the value of `msi_en`, vector v is written with the address and data last loaded into table entry v through `tbl_wr_*`.
- R7: A vector's pending bit is set only by a 0-to-1 edge of its request while a message mode is enabled. A held level does not set it again. The bit is cleared when that vector's write is accepted.
- R8: When several vectors are pending, the lowest-numbered one is offered first.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_kind`, `out_addr` and `out_data` stay unchanged. After an accepting edge `out_valid` is 0 for at least one cycle.
- R10: `out_kind` never takes the value 3 while `out_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | NUM_VEC | Per-vector request levels from device logic |
| msi_en | input | 1 | Single-address message mode enable |
| msix_en | input | 1 | Table message mode enable (takes precedence) |
| intx_pin | input | 2 | Legacy pin code, 0=A to 3=D |
| msi_addr | input | ADDR_W | Single-address mode write address |
| msi_data | input | DATA_W | Single-address mode base data |
| tbl_wr_en | input | 1 | Table entry write strobe |
| tbl_wr_idx | input | VEC_W | Table entry index |
| tbl_wr_addr | input | ADDR_W | Address written into the entry |
| tbl_wr_data | input | DATA_W | Data written into the entry |
| out_valid | output | 1 | Message request valid |
| out_ready | input | 1 | Consumer accepts the request |
| out_kind | output | 2 | 0 wire assert, 1 wire deassert, 2 memory write |
| out_addr | output | ADDR_W | Write address, zero for wire messages |
| out_data | output | DATA_W | Write data or pin code |

## Verification
The assertions check the stream contract on every cycle: request fields hold still under back-pressure, valid drops after each accept, no reserved kind appears, wire messages carry a zero address, and no wire-assert is issued while a message mode is enabled. Other behaviour can only be shown by the bench's scenarios. These are the legacy level tracking with its pin code, the forced deassert on entering message mode, the data merge in single-address mode, the per-entry table lookup, lowest-vector-first ordering, and the rule that a held request level does not fire again.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  typedef enum logic [1:0] {
    KIND_WIRE_ON  = 2'd0,
    KIND_WIRE_OFF = 2'd1,
    KIND_MEM_WR   = 2'd2
  } msg_kind_e;
endpackage

// File: rtl/irq_edge_pend.sv
module irq_edge_pend #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          arm,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  pend
);
  logic [N-1:0] req_q;
  logic [N-1:0] clr_mask;
  logic [N-1:0] rise;

  for (genvar g = 0; g < N; g++) begin : g_clr
    assign clr_mask[g] = clr_en && (clr_idx == IW'(g));
  end

  assign rise = req & ~req_q & {N{arm}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      pend  <= '0;
    end else begin
      req_q <= req;
      // a fresh edge wins over a same-cycle clear
      pend  <= (pend & ~clr_mask) | rise;
    end
  end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
  assign any = |vec;
endmodule

// File: rtl/irq_msix_table.sv
module irq_msix_table #(
  parameter int N  = 8,
  parameter int IW = 3,
  parameter int AW = 64,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [AW-1:0] addr_q [N];
  logic [DW-1:0] data_q [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_q[g] <= '0;
        data_q[g] <= '0;
      end else if (wr_en && wr_idx == IW'(g)) begin
        addr_q[g] <= wr_addr;
        data_q[g] <= wr_data;
      end
    end
  end

  assign rd_addr = addr_q[rd_idx];
  assign rd_data = data_q[rd_idx];
endmodule

// File: rtl/irq_signal_sel.sv
module irq_signal_sel
  import irq_sel_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int ADDR_W  = 64,
  parameter int DATA_W  = 32,
  localparam int VEC_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] irq_req,
  input  logic               msi_en,
  input  logic               msix_en,
  input  logic [1:0]         intx_pin,
  input  logic [ADDR_W-1:0]  msi_addr,
  input  logic [DATA_W-1:0]  msi_data,
  input  logic               tbl_wr_en,
  input  logic [VEC_W-1:0]   tbl_wr_idx,
  input  logic [ADDR_W-1:0]  tbl_wr_addr,
  input  logic [DATA_W-1:0]  tbl_wr_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [1:0]         out_kind,
  output logic [ADDR_W-1:0]  out_addr,
  output logic [DATA_W-1:0]  out_data
);
  logic               msg_mode;
  logic               line_lvl;
  logic               wire_on;
  logic [NUM_VEC-1:0] pend;
  logic               pick_any;
  logic [VEC_W-1:0]   pick_idx;
  logic [ADDR_W-1:0]  tbl_addr;
  logic [DATA_W-1:0]  tbl_data;
  logic [VEC_W-1:0]   out_vec;
  logic               accept;

  logic               nxt_valid;
  msg_kind_e          nxt_kind;
  logic [ADDR_W-1:0]  nxt_addr;
  logic [DATA_W-1:0]  nxt_data;

  assign msg_mode = msi_en | msix_en;
  assign line_lvl = |irq_req;
  assign accept   = out_valid & out_ready;

  irq_edge_pend #(.N(NUM_VEC), .IW(VEC_W)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (irq_req),
    .arm     (msg_mode),
    .clr_en  (accept && out_kind == KIND_MEM_WR),
    .clr_idx (out_vec),
    .pend    (pend)
  );

  irq_lowest_pick #(.N(NUM_VEC), .IW(VEC_W)) u_pick (
    .vec (pend),
    .any (pick_any),
    .idx (pick_idx)
  );

  irq_msix_table #(.N(NUM_VEC), .IW(VEC_W), .AW(ADDR_W), .DW(DATA_W)) u_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_wr_en),
    .wr_idx  (tbl_wr_idx),
    .wr_addr (tbl_wr_addr),
    .wr_data (tbl_wr_data),
    .rd_idx  (pick_idx),
    .rd_addr (tbl_addr),
    .rd_data (tbl_data)
  );

  // choose the next request: stuck-wire release, then wire tracking, then vector writes
  always_comb begin
    nxt_valid = 1'b0;
    nxt_kind  = KIND_WIRE_OFF;
    nxt_addr  = '0;
    nxt_data  = DATA_W'(intx_pin);
    if (msg_mode && wire_on) begin
      nxt_valid = 1'b1;
    end else if (!msg_mode && (line_lvl != wire_on)) begin
      nxt_valid = 1'b1;
      nxt_kind  = line_lvl ? KIND_WIRE_ON : KIND_WIRE_OFF;
    end else if (msg_mode && pick_any) begin
      nxt_valid = 1'b1;
      nxt_kind  = KIND_MEM_WR;
      if (msix_en) begin
        nxt_addr = tbl_addr;
        nxt_data = tbl_data;
      end else begin
        nxt_addr = msi_addr;
        nxt_data = msi_data | DATA_W'(pick_idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_kind  <= 2'd0;
      out_addr  <= '0;
      out_data  <= '0;
      out_vec   <= '0;
      wire_on   <= 1'b0;
    end else if (out_valid) begin
      if (out_ready) begin
        out_valid <= 1'b0;
        if (out_kind == KIND_WIRE_ON)  wire_on <= 1'b1;
        if (out_kind == KIND_WIRE_OFF) wire_on <= 1'b0;
      end
    end else if (nxt_valid) begin
      out_valid <= 1'b1;
      out_kind  <= nxt_kind;
      out_addr  <= nxt_addr;
      out_data  <= nxt_data;
      out_vec   <= pick_idx;
    end
  end
endmodule

// File: rtl/irq_signal_sel_chk.sv
module irq_signal_sel_chk #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msi_en,
  input logic              msix_en,
  input logic              out_valid,
  input logic              out_ready,
  input logic [1:0]        out_kind,
  input logic [ADDR_W-1:0] out_addr,
  input logic [DATA_W-1:0] out_data
);
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) &&
                                   $stable(out_addr) && $stable(out_data)));

  p_one_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);

  p_kind_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_kind != 2'd3));

  p_no_assert_msg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_valid) && out_kind == 2'd0) |-> !$past(msi_en || msix_en));

  p_wire_zero_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind != 2'd2) |-> (out_addr == '0));
endmodule

bind irq_signal_sel irq_signal_sel_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .msi_en    (msi_en),
  .msix_en   (msix_en),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_kind  (out_kind),
  .out_addr  (out_addr),
  .out_data  (out_data)
);

// File: tb/irq_signal_sel_tb.sv
module irq_signal_sel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int IW = 3;
  localparam int AW = 64;
  localparam int DW = 32;
  localparam logic [AW-1:0] MSI_A = 64'h0000_0000_FEE0_1000;
  localparam logic [DW-1:0] MSI_D = 32'h0000_4A40;
  // bit 3: table mode, bits 2:0: vector
  localparam logic [3:0] STIM [6] = '{4'b1000, 4'b1111, 4'b0010, 4'b1100, 4'b0111, 4'b1011};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_req = '0;
  logic          msi_en = 1'b0, msix_en = 1'b0;
  logic [1:0]    intx_pin = 2'd2;
  logic          tbl_wr_en = 1'b0;
  logic [IW-1:0] tbl_wr_idx = '0;
  logic [AW-1:0] tbl_wr_addr = '0;
  logic [DW-1:0] tbl_wr_data = '0;
  logic          out_valid, out_ready = 1'b0;
  logic [1:0]    out_kind;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_data;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_signal_sel #(.NUM_VEC(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .msi_en(msi_en), .msix_en(msix_en),
    .intx_pin(intx_pin), .msi_addr(MSI_A), .msi_data(MSI_D),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_addr(tbl_wr_addr),
    .tbl_wr_data(tbl_wr_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_kind(out_kind), .out_addr(out_addr), .out_data(out_data)
  );

  function automatic logic [AW-1:0] ent_addr(int v);
    return 64'hFEE0_0000_0000_1000 + AW'(v * 16);
  endfunction
  function automatic logic [DW-1:0] ent_data(int v);
    return 32'hC0DE_0000 + DW'(v * 3 + 1);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // wait for a request at a falling edge, capture it, accept it
  task automatic take(output bit got, output logic [1:0] k, output logic [AW-1:0] a,
                      output logic [DW-1:0] d);
    got = 1'b0; k = 2'd3; a = '0; d = '0;
    for (int i = 0; i < 16 && !got; i++) begin
      @(negedge clk);
      if (out_valid) begin
        got = 1'b1; k = out_kind; a = out_addr; d = out_data;
      end
    end
    if (got) begin
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
  endtask

  task automatic quiet(input int cycles, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (out_valid) seen = 1'b1;
    end
    check(!seen, tag, AW'(seen), '0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      finish_run();
    end
  end

  initial begin
    bit got;
    logic [1:0] k;
    logic [AW-1:0] a;
    logic [DW-1:0] d;

    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 reset valid", AW'(out_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 idle after reset", AW'(out_valid), '0);

    // load every table entry
    for (int v = 0; v < N; v++) begin
      tbl_wr_en = 1'b1; tbl_wr_idx = IW'(v);
      tbl_wr_addr = ent_addr(v); tbl_wr_data = ent_data(v);
      @(negedge clk);
    end
    tbl_wr_en = 1'b0;

    // vector table walk: single-address and table writes, msi_en held on (R6 precedence)
    msi_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      int v = int'(STIM[i][2:0]);
      msix_en = STIM[i][3];
      @(negedge clk);
      irq_req[v] = 1'b1;
      take(got, k, a, d);
      check(got && k == 2'd2, "R5/R6 write kind", AW'(k), 64'd2);
      if (STIM[i][3]) begin
        check(a == ent_addr(v), "R6 table address", a, ent_addr(v));
        check(d == ent_data(v), "R6 table data", AW'(d), AW'(ent_data(v)));
      end else begin
        check(a == MSI_A, "R5 address", a, MSI_A);
        check(d == (MSI_D | DW'(v)), "R5 data merge", AW'(d), AW'(MSI_D | DW'(v)));
      end
      irq_req[v] = 1'b0;
    end
    msix_en = 1'b0;
    quiet(4, "R7 pending cleared after accept");

    // priority: two edges together, lowest first (R8)
    irq_req[5] = 1'b1; irq_req[3] = 1'b1;
    take(got, k, a, d);
    check(d == (MSI_D | 32'd3), "R8 lowest first", AW'(d), AW'(MSI_D | 32'd3));
    take(got, k, a, d);
    check(d == (MSI_D | 32'd5), "R8 second vector", AW'(d), AW'(MSI_D | 32'd5));
    quiet(4, "R7 held level no retrigger");
    irq_req = '0;

    // back-pressure hold (R9)
    @(negedge clk);
    irq_req[1] = 1'b1;
    for (int i = 0; i < 4; i++) @(negedge clk);
    check(out_valid == 1'b1, "R9 valid offered", AW'(out_valid), 64'd1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(out_valid && out_data == (MSI_D | 32'd1), "R9 held under back-pressure",
            AW'(out_data), AW'(MSI_D | 32'd1));
    end
    take(got, k, a, d);
    check(got && d == (MSI_D | 32'd1), "R9 accepted value", AW'(d), AW'(MSI_D | 32'd1));
    irq_req = '0;
    msi_en = 1'b0;
    @(negedge clk);

    // legacy level tracking (R2, R3)
    irq_req[2] = 1'b1;
    take(got, k, a, d);
    check(got && k == 2'd0, "R2 assert kind", AW'(k), 64'd0);
    check(d == 32'd2 && a == '0, "R2 pin code C", AW'(d), 64'd2);
    irq_req[5] = 1'b1;
    quiet(4, "R2 no repeat while asserted");
    irq_req[2] = 1'b0;
    quiet(3, "R3 level still high");
    irq_req[5] = 1'b0;
    take(got, k, a, d);
    check(got && k == 2'd1, "R3 deassert kind", AW'(k), 64'd1);
    check(d == 32'd2, "R3 pin code", AW'(d), 64'd2);

    // stuck-wire release on entering message mode (R4, R7)
    intx_pin = 2'd0;
    irq_req[0] = 1'b1;
    take(got, k, a, d);
    check(got && k == 2'd0 && d == 32'd0, "R2 pin code A", AW'(d), 64'd0);
    msi_en = 1'b1;
    take(got, k, a, d);
    check(got && k == 2'd1, "R4 forced deassert", AW'(k), 64'd1);
    quiet(4, "R7 level before enable no write");
    irq_req[6] = 1'b1;
    take(got, k, a, d);
    check(got && k == 2'd2, "R4 write not assert", AW'(k), 64'd2);
    irq_req = '0;
    quiet(3, "R4 no wire message in message mode");

    finish_run();
  end
endmodule